// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits on the outbound path of a PCIe root port. It turns a CPU-side address into a bus address and picks the attribute word that the downstream transaction generator uses. The block holds a parameter number of windows, eight by default. Each window stores a 64-bit compare value, a 64-bit replacement value, a 64-bit mask and a 32-bit attribute word. A separate fallback attribute word applies to any address that no window claims.

Software programs the windows through a simple write-only register port with 32-bit data. A lookup request gives an address. One clock later the block returns the translated address, a hit flag, the index of the winning window and the selected attribute word. The mask is aligned to a 64 KiB granule, so the low 16 address bits always pass through unchanged.

Top module: `obwin_xlate`

## Requirements
- R1: After a synchronous active-low reset, res_valid is 0, every window is disabled and the fallback attribute word is 0.
- R2: An address hits window w when the window is enabled (bit 0 of its compare-low register) and (address AND mask) equals (compare AND mask). Compare bit 0 takes no part in the compare.
- R3: Mask bits [15:0] read as zero whatever is written. As a result, result address bits [15:0] always equal the request address bits [15:0].
- R4: On a hit, the result address takes the replacement value in the bit positions where the mask is set, and the request address bits everywhere else.
- R5: When several enabled windows hit, the window with the lowest index wins.
- R6: On a miss, res_hit is 0, res_win is 0, the result address equals the request address, and res_actions equals the fallback word.
- R7: On a hit, res_win gives the winning window index and res_actions gives that window's attribute word.
- R8: Clearing a window's enable bit stops that window from hitting from the next lookup on.
- R9: A request with lk_valid high in one cycle gives res_valid high in the next cycle. A cycle without a request gives res_valid low in the next cycle.
- R10: A register write and a lookup in the same cycle: the lookup uses the register contents from before the write.
- R11: Register byte offsets: window w starts at w*0x20. Its slots are compare low 0x00, compare high 0x04, replacement low 0x08, replacement high 0x0C, mask low 0x10, mask high 0x14 and attribute 0x18. The fallback word is at (N-1)*0x20+0x1C (0xFC by default). A write to offset 0x1C of any other window has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_off | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 64 | Address to translate |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | A window claimed the address |
| res_win | output | 3 | Index of the winning window |
| res_addr | output | 64 | Translated address |
| res_actions | output | 32 | Selected attribute word |

## Verification
A register write and a lookup can arrive in the same cycle. The most telling case is a write that enables a window, or moves its fallback, while a lookup for an address inside that window is in flight. The bench issues such a write together with a lookup. It expects the lookup to report the state from before the write, and expects the very next lookup to show the new state. Overlapping windows are also used, to show that the priority order holds while enables change between consecutive lookups.

// File: rtl/obwin_pkg.sv
// Package: shared constants and register slot encoding for the outbound
// window translator. Assumes 32-bit register data and 64-bit addresses.
package obwin_pkg;
    localparam int unsigned OBW_DATA_W   = 32;
    localparam int unsigned OBW_ADDR_W   = 64;
    localparam int unsigned OBW_GRAN_W   = 16;
    localparam int unsigned OBW_WIN_SPAN = 32;

    // Slot within a window's 32-byte register block, from offset bits [4:2]
    typedef enum logic [2:0] {
        SLOT_CMP_LO  = 3'd0,
        SLOT_CMP_HI  = 3'd1,
        SLOT_REP_LO  = 3'd2,
        SLOT_REP_HI  = 3'd3,
        SLOT_MSK_LO  = 3'd4,
        SLOT_MSK_HI  = 3'd5,
        SLOT_ATTR    = 3'd6,
        SLOT_SPARE   = 3'd7
    } obw_slot_e;
endpackage

// File: rtl/obwin_regfile.sv
// Register store for all windows and the fallback attribute word.
// Assumes ADDR_W == 2*DATA_W and GRAN_W < DATA_W. Writes take effect at
// the clock edge; mask bits below GRAN_W are never stored.
module obwin_regfile
    import obwin_pkg::*;
#(
    parameter int unsigned NWIN   = 8,
    parameter int unsigned DATA_W = OBW_DATA_W,
    parameter int unsigned ADDR_W = OBW_ADDR_W,
    parameter int unsigned GRAN_W = OBW_GRAN_W,
    parameter int unsigned OFF_W  = $clog2(NWIN) + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] cmp_o  [NWIN],
    output logic [ADDR_W-1:0] rep_o  [NWIN],
    output logic [ADDR_W-1:0] msk_o  [NWIN],
    output logic [DATA_W-1:0] attr_o [NWIN],
    output logic              en_o   [NWIN],
    output logic [DATA_W-1:0] dflt_o
);
    localparam int unsigned WIN_W = OFF_W - 5;

    logic [WIN_W-1:0] win_sel;
    obw_slot_e        slot;

    // Split the byte offset into window index and slot
    always_comb begin
        win_sel = off[OFF_W-1:5];
        slot    = obw_slot_e'(off[4:2]);
    end

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        logic [DATA_W-1:1]      cmp_lo_q;
        logic                   en_q;
        logic [DATA_W-1:0]      cmp_hi_q, rep_lo_q, rep_hi_q, msk_hi_q, attr_q;
        logic [DATA_W-1:GRAN_W] msk_lo_q;
        logic                   sel;

        assign sel = we && (win_sel == WIN_W'(w));

        // Per-window register update
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q     <= 1'b0;
                cmp_lo_q <= '0;
                cmp_hi_q <= '0;
                rep_lo_q <= '0;
                rep_hi_q <= '0;
                msk_lo_q <= '0;
                msk_hi_q <= '0;
                attr_q   <= '0;
            end else if (sel) begin
                case (slot)
                    SLOT_CMP_LO: begin
                        en_q     <= wdata[0];
                        cmp_lo_q <= wdata[DATA_W-1:1];
                    end
                    SLOT_CMP_HI: cmp_hi_q <= wdata;
                    SLOT_REP_LO: rep_lo_q <= wdata;
                    SLOT_REP_HI: rep_hi_q <= wdata;
                    SLOT_MSK_LO: msk_lo_q <= wdata[DATA_W-1:GRAN_W];
                    SLOT_MSK_HI: msk_hi_q <= wdata;
                    SLOT_ATTR:   attr_q   <= wdata;
                    default: ;
                endcase
            end
        end

        // Present stored fields as full-width vectors
        always_comb begin
            cmp_o[w]  = {cmp_hi_q, cmp_lo_q, 1'b0};
            rep_o[w]  = {rep_hi_q, rep_lo_q};
            msk_o[w]  = {msk_hi_q, msk_lo_q, {GRAN_W{1'b0}}};
            attr_o[w] = attr_q;
            en_o[w]   = en_q;
        end
    end

    logic dflt_sel;
    assign dflt_sel = we && (win_sel == WIN_W'(NWIN - 1)) && (slot == SLOT_SPARE);

    // Fallback attribute word update
    always_ff @(posedge clk) begin
        if (!rst_n)        dflt_o <= '0;
        else if (dflt_sel) dflt_o <= wdata;
    end

    assert_dflt_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (we && off == OFF_W'((NWIN - 1) * OBW_WIN_SPAN + 28)) |=> dflt_o == $past(wdata));

    assert_spare_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (we && off[4:2] == 3'd7 && off[OFF_W-1:5] != WIN_W'(NWIN - 1)) |=> $stable(dflt_o));
endmodule

// File: rtl/obwin_match.sv
// Per-window hit detection: a window hits when enabled and the masked
// address equals the masked compare value. Purely combinational.
module obwin_match #(
    parameter int unsigned NWIN   = 8,
    parameter int unsigned ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] cmp [NWIN],
    input  logic [ADDR_W-1:0] msk [NWIN],
    input  logic              en  [NWIN],
    output logic [NWIN-1:0]   hit_vec
);
    for (genvar w = 0; w < NWIN; w++) begin : g_cmp
        // Masked equality compare for one window
        always_comb begin
            hit_vec[w] = en[w] && ((addr & msk[w]) == (cmp[w] & msk[w]));
        end
    end
endmodule

// File: rtl/obwin_select.sv
// Priority pick (lowest index wins) and address substitution. Falls back
// to pass-through and the fallback attribute word on a miss.
module obwin_select #(
    parameter int unsigned NWIN   = 8,
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NWIN-1:0]   hit_vec,
    input  logic [ADDR_W-1:0] rep  [NWIN],
    input  logic [ADDR_W-1:0] msk  [NWIN],
    input  logic [DATA_W-1:0] attr [NWIN],
    input  logic [DATA_W-1:0] dflt,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] xaddr,
    output logic [DATA_W-1:0] act
);
    logic [NWIN-1:0] grant;

    // Lowest-index grant, scanning from the top down
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int w = NWIN - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                grant    = '0;
                grant[w] = 1'b1;
                idx      = IDX_W'(w);
            end
        end
        hit = |hit_vec;
    end

    // Substitute masked bits and pick the attribute word
    always_comb begin
        xaddr = addr;
        act   = dflt;
        if (hit) begin
            xaddr = (rep[idx] & msk[idx]) | (addr & ~msk[idx]);
            act   = attr[idx];
        end
    end

    assert_grant_lowest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (((grant - 1'b1) & hit_vec) == '0));
endmodule

// File: rtl/obwin_xlate.sv
// Top: outbound address window translator. Register writes and lookups
// share one clock; a lookup sees registers as they were before any write
// in the same cycle; results are registered, one cycle after the request.
module obwin_xlate
    import obwin_pkg::*;
#(
    parameter int unsigned NWIN   = 8,
    parameter int unsigned DATA_W = OBW_DATA_W,
    parameter int unsigned ADDR_W = OBW_ADDR_W,
    parameter int unsigned GRAN_W = OBW_GRAN_W,
    parameter int unsigned OFF_W  = $clog2(NWIN) + 5,
    parameter int unsigned IDX_W  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [OFF_W-1:0]  cfg_off,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic [IDX_W-1:0]  res_win,
    output logic [ADDR_W-1:0] res_addr,
    output logic [DATA_W-1:0] res_actions
);
    logic [ADDR_W-1:0] cmp  [NWIN];
    logic [ADDR_W-1:0] rep  [NWIN];
    logic [ADDR_W-1:0] msk  [NWIN];
    logic [DATA_W-1:0] attr [NWIN];
    logic              en   [NWIN];
    logic [DATA_W-1:0] dflt;
    logic [NWIN-1:0]   hit_vec;
    logic              nx_hit;
    logic [IDX_W-1:0]  nx_idx;
    logic [ADDR_W-1:0] nx_addr;
    logic [DATA_W-1:0] nx_act;

    obwin_regfile #(.NWIN(NWIN), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                    .GRAN_W(GRAN_W), .OFF_W(OFF_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .off(cfg_off), .wdata(cfg_wdata),
        .cmp_o(cmp), .rep_o(rep), .msk_o(msk), .attr_o(attr), .en_o(en),
        .dflt_o(dflt)
    );

    obwin_match #(.NWIN(NWIN), .ADDR_W(ADDR_W)) u_match (
        .addr(lk_addr), .cmp(cmp), .msk(msk), .en(en), .hit_vec(hit_vec)
    );

    obwin_select #(.NWIN(NWIN), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                   .IDX_W(IDX_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .addr(lk_addr), .hit_vec(hit_vec),
        .rep(rep), .msk(msk), .attr(attr), .dflt(dflt),
        .hit(nx_hit), .idx(nx_idx), .xaddr(nx_addr), .act(nx_act)
    );

    // Result register: capture the lookup outcome for one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_hit     <= 1'b0;
            res_win     <= '0;
            res_addr    <= '0;
            res_actions <= '0;
        end else begin
            res_valid <= lk_valid;
            if (lk_valid) begin
                res_hit     <= nx_hit;
                res_win     <= nx_idx;
                res_addr    <= nx_addr;
                res_actions <= nx_act;
            end
        end
    end

    assert_req_gives_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    assert_idle_gives_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    assert_low_bits_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_addr[GRAN_W-1:0] == $past(lk_addr[GRAN_W-1:0]));

    assert_miss_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (res_hit || (res_addr == $past(lk_addr) && res_win == '0)));
endmodule

// File: tb/obwin_xlate_tb.sv
// Scoreboard bench: a driver task pushes one expected item per cycle, a
// monitor pops it one clock later and compares it with the result ports.
module obwin_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_off = '0;
    logic [31:0] cfg_wdata = '0;
    logic        lk_valid = 1'b0;
    logic [63:0] lk_addr = '0;
    logic        res_valid, res_hit;
    logic [2:0]  res_win;
    logic [63:0] res_addr;
    logic [31:0] res_actions;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    obwin_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_off(cfg_off),
        .cfg_wdata(cfg_wdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .res_valid(res_valid), .res_hit(res_hit), .res_win(res_win),
        .res_addr(res_addr), .res_actions(res_actions)
    );

    typedef struct {
        bit          valid;
        bit          hit;
        logic [2:0]  win;
        logic [63:0] addr;
        logic [31:0] act;
        string       req;
    } exp_t;

    exp_t q[$];

    // Bench-side model of the register contents
    logic [31:0] m_clo[8], m_chi[8], m_rlo[8], m_rhi[8], m_klo[8], m_khi[8], m_att[8];
    logic [31:0] m_dflt;

    task automatic model_reset();
        for (int w = 0; w < 8; w++) begin
            m_clo[w] = 0; m_chi[w] = 0; m_rlo[w] = 0; m_rhi[w] = 0;
            m_klo[w] = 0; m_khi[w] = 0; m_att[w] = 0;
        end
        m_dflt = 0;
    endtask

    task automatic model_write(input logic [7:0] off, input logic [31:0] d);
        int w = off[7:5];
        case (off[4:2])
            3'd0: m_clo[w] = d;
            3'd1: m_chi[w] = d;
            3'd2: m_rlo[w] = d;
            3'd3: m_rhi[w] = d;
            3'd4: m_klo[w] = d & 32'hFFFF_0000;
            3'd5: m_khi[w] = d;
            3'd6: m_att[w] = d;
            default: if (w == 7) m_dflt = d;
        endcase
    endtask

    function automatic exp_t model_lookup(input logic [63:0] a);
        exp_t e;
        e.valid = 1'b1; e.hit = 1'b0; e.win = 0; e.addr = a; e.act = m_dflt; e.req = "";
        for (int w = 7; w >= 0; w--) begin
            logic [63:0] k, c, r;
            k = {m_khi[w], m_klo[w]};
            c = {m_chi[w], m_clo[w] & 32'hFFFF_FFFE};
            r = {m_rhi[w], m_rlo[w]};
            if (m_clo[w][0] && ((a & k) == (c & k))) begin
                e.hit = 1'b1; e.win = 3'(w); e.addr = (r & k) | (a & ~k); e.act = m_att[w];
            end
        end
        return e;
    endfunction

    // One cycle of stimulus: optional write and optional lookup
    task automatic step(input bit wr, input logic [7:0] off, input logic [31:0] d,
                        input bit lk, input logic [63:0] a, input string req);
        exp_t e;
        @(negedge clk);
        cfg_we = wr; cfg_off = off; cfg_wdata = d; lk_valid = lk; lk_addr = a;
        e = model_lookup(a);
        e.valid = lk;
        e.req = req;
        q.push_back(e);
        if (wr) model_write(off, d);
    endtask

    task automatic wr(input logic [7:0] off, input logic [31:0] d);
        step(1'b1, off, d, 1'b0, 64'h0, "R9");
    endtask

    task automatic lk(input logic [63:0] a, input string req);
        step(1'b0, 8'h0, 32'h0, 1'b1, a, req);
    endtask

    function automatic logic [7:0] offs(input int w, input int slot);
        return 8'(w * 32 + slot * 4);
    endfunction

    // Monitor: compare each result against the oldest expected item
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (res_valid !== e.valid ||
                (e.valid && (res_hit !== e.hit || res_win !== e.win ||
                             res_addr !== e.addr || res_actions !== e.act))) begin
                fails++;
                $display("FAIL %s: got v=%0b hit=%0b win=%0d addr=%h act=%h, expected v=%0b hit=%0b win=%0d addr=%h act=%h",
                         e.req, res_valid, res_hit, res_win, res_addr, res_actions,
                         e.valid, e.hit, e.win, e.addr, e.act);
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #250000;
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1: reset state
        checks++;
        if (res_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: got res_valid=%0b, expected 0", res_valid);
        end
        // R1/R6: nothing enabled, fallback is zero
        lk(64'h1234_5678_9ABC_DEF0, "R1");
        // R11: fallback word at 0xFC, then miss uses it
        wr(8'hFC, 32'h0000_000C);
        lk(64'h0000_00AA_0000_1111, "R6");
        // Window 0: 256 MiB at 0xE000_0000 -> 0x10_2000_0000
        wr(offs(0, 4), 32'hF000_0000);
        wr(offs(0, 5), 32'hFFFF_FFFF);
        wr(offs(0, 2), 32'h2000_0000);
        wr(offs(0, 3), 32'h0000_0010);
        wr(offs(0, 6), 32'h0000_0384);
        wr(offs(0, 0), 32'hE000_0001);
        lk(64'h0000_0000_E123_4567, "R2 R4 R7");
        lk(64'h0000_0000_D000_0000, "R6");
        lk(64'h0000_0001_E000_0000, "R2");
        // Window 3: mask written all ones, low 16 bits must be dropped
        wr(offs(3, 4), 32'hFFFF_FFFF);
        wr(offs(3, 5), 32'hFFFF_FFFF);
        wr(offs(3, 2), 32'h0003_FFFF);
        wr(offs(3, 3), 32'h0000_0002);
        wr(offs(3, 6), 32'h0000_0009);
        wr(offs(3, 1), 32'h0000_0001);
        wr(offs(3, 0), 32'h0000_ABCD);
        lk(64'h0000_0001_0000_1234, "R3 R4");
        // Window 5 overlaps window 0
        wr(offs(5, 4), 32'hFF00_0000);
        wr(offs(5, 5), 32'hFFFF_FFFF);
        wr(offs(5, 3), 32'h0000_0030);
        wr(offs(5, 6), 32'h0000_0008);
        wr(offs(5, 0), 32'hE100_0001);
        lk(64'h0000_0000_E100_0010, "R5");
        // R11: spare slot of window 0 has no effect on fallback
        wr(offs(0, 7), 32'hFFFF_FFFF);
        lk(64'h0000_0000_0000_0042, "R11");
        // R8: disable window 0, window 5 takes over, rest of window 0 misses
        wr(offs(0, 0), 32'hE000_0000);
        lk(64'h0000_0000_E100_0010, "R8");
        lk(64'h0000_0000_E200_0000, "R8");
        // R10: enable window 6 in the same cycle as a lookup into it
        wr(offs(6, 4), 32'hFFFF_0000);
        wr(offs(6, 5), 32'hFFFF_FFFF);
        wr(offs(6, 6), 32'h0000_0004);
        step(1'b1, offs(6, 0), 32'h0050_0001, 1'b1, 64'h0000_0000_0050_7777, "R10");
        lk(64'h0000_0000_0050_7777, "R10");
        // R10: fallback change in the same cycle as a miss
        step(1'b1, 8'hFC, 32'h0000_0000, 1'b1, 64'h0000_0000_7000_0000, "R10");
        lk(64'h0000_0000_7000_0000, "R10");
        // R9: back-to-back lookups, then idle
        lk(64'h0000_0000_E1FF_0000, "R9");
        lk(64'h0000_0001_0000_0000, "R9");
        step(1'b0, 8'h0, 32'h0, 1'b0, 64'h0, "R9");
        step(1'b0, 8'h0, 32'h0, 1'b0, 64'h0, "R9");
        @(negedge clk);
        lk_valid = 1'b0; cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R9: got %0d pending results, expected 0", q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule